// File: doc/BRIEF.md
# Selectable-Order MASH Fractional Modulator

This block sits beside the feedback divider of a fractional-N synthesizer. It produces one small signed correction per comparison period. The divider adds that correction to its integer ratio, and over time the corrections average to a programmed fraction. The fraction word is 18 bits wide. A control bit can append a nineteenth, least significant bit set to one. The accumulators therefore always work on a 19-bit word, x = 2·K + lsb_en, and the fraction is x / 2^19. This extra bit breaks up the short repeating patterns that large, coarse K values would otherwise produce.

Three cascaded first-order accumulators generate carries. The carries are recombined by differencing, which gives a second-order (1-1) or third-order (1-1-1) noise-shaped sequence. The `order3` pin selects the order at run time. The divider's `step_en` strobe paces the block, so there is one update per strobe. The output is a plain registered value that is valid from the strobe edge until the next strobe. There is no back-pressure: the divider always consumes the value, so no ready signal exists. A K of zero holds every stage clear and forces the correction to zero, which is integer-N operation.

Top module: `mash_sdm`

## Requirements
- R1: After reset the `offset` output is 0.
- R2: On each clock edge with `step_en` high and no clear, the block advances as follows. Stage 1 adds x = {frac_k, lsb_en} to its 19-bit register, and its carry c1 is bit 19 of that sum. Stage 2 adds the new stage-1 value, with carry c2. Stage 3 adds the new stage-2 value, with carry c3. `offset` then takes c1 + c2 − c2p in 1-1 mode, or c1 + c2 − c2p + c3 − 2·c3p + c3pp in 1-1-1 mode. Here c2p and c3p are the carries of the previous strobe, c3pp is the carry of the strobe before that, and all three are 0 after a clear.
- R3: With `order3` = 0 (1-1 mode), `offset` stays within −1..+2.
- R4: With `order3` = 1 (1-1-1 mode), `offset` stays within −3..+4.
- R5: While `frac_k` is zero, `offset` is 0 from the next edge on, whatever `lsb_en` is. All stage and delay registers are held clear, so a later nonzero K starts from a cleared state.
- R6: On edges with `step_en` low, `offset` and all internal state hold.
- R7: The first edge on which `order3` differs from its value at the previous edge clears all stage and delay registers and sets `offset` to 0, even if `step_en` is high on that edge. The sequence that follows equals the sequence after a reset.
- R8: Over the first N strobes after a clear, the sum of the `offset` values differs from floor(N·x / 2^19) by no more than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frac_k | input | FRAC_W (18) | Fractional word K |
| lsb_en | input | 1 | Appends a one as the extra LSB of the accumulator input |
| order3 | input | 1 | 0 = 1-1 cascade, 1 = 1-1-1 cascade |
| step_en | input | 1 | Divider strobe; one modulator update per high edge |
| offset | output | OUT_W (4) | Signed correction to the integer divide ratio |

## Verification
The bench drives a range of fraction words. These include the smallest nonzero word, one half, the all-ones word with the extra LSB set, and irregular words. The bench steps each one with back-to-back strobes and with strobes spaced by idle cycles. Comparing every output against an independent step model distinguishes errors in carry chaining, delay alignment and the third-order weighting. The accumulated sum separates a correct long-run mean from an off-by-one in the input word. The idle cycles show that nothing moves without a strobe. Directed runs then cover integer mode, with its clear-on-exit, and a mid-stream change of order.

// File: rtl/mash_pkg.sv
package mash_pkg;
  typedef enum logic {
    MODE_2ND = 1'b0,
    MODE_3RD = 1'b1
  } mash_mode_e;

  localparam int unsigned NSTAGE = 3;
endpackage

// File: rtl/mash_stage.sv
// One first-order accumulator of the cascade. The next value and its carry
// are combinational, so the following stage can add the fresh sum in the
// same update.
module mash_stage #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_next,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   wide;

  always_comb begin
    wide     = {1'b0, acc_q} + {1'b0, addend};
    sum_next = wide[W-1:0];
    carry    = wide[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (adv)      acc_q <= sum_next;
  end
endmodule

// File: rtl/mash_combine.sv
// Carry recombination: first difference of c2 and, in third-order mode,
// the second difference of c3. The result is registered per strobe.
module mash_combine #(
  parameter int OUT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    adv,
  input  logic                    mode3,
  input  logic                    c1,
  input  logic                    c2,
  input  logic                    c3,
  output logic signed [OUT_W-1:0] offset
);
  logic c2_d, c3_d, c3_dd;
  logic signed [OUT_W-1:0] e1, e2, e2d, e3, e3d, e3dd, third, y;

  always_comb begin
    e1    = OUT_W'(c1);
    e2    = OUT_W'(c2);
    e2d   = OUT_W'(c2_d);
    e3    = OUT_W'(c3);
    e3d   = OUT_W'(c3_d);
    e3dd  = OUT_W'(c3_dd);
    third = e3 - (e3d <<< 1) + e3dd;
    y     = e1 + e2 - e2d + (mode3 ? third : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      c2_d   <= 1'b0;
      c3_d   <= 1'b0;
      c3_dd  <= 1'b0;
      offset <= '0;
    end else if (adv) begin
      c2_d   <= c2;
      c3_d   <= c3;
      c3_dd  <= c3_d;
      offset <= y;
    end
  end
endmodule

// File: rtl/mash_sdm.sv
module mash_sdm
  import mash_pkg::*;
#(
  parameter int FRAC_W = 18,
  parameter int OUT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FRAC_W-1:0]       frac_k,
  input  logic                    lsb_en,
  input  logic                    order3,
  input  logic                    step_en,
  output logic signed [OUT_W-1:0] offset
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0]  word;
  logic              kzero, clr, adv;
  mash_mode_e        mode_q;
  logic [ACC_W-1:0]  link [NSTAGE];
  logic [ACC_W-1:0]  tail_unused;
  logic [NSTAGE-1:0] carry;

  assign word  = {frac_k, lsb_en};
  assign kzero = (frac_k == '0);
  assign clr   = kzero || (mash_mode_e'(order3) != mode_q);
  assign adv   = step_en && !clr;
  assign link[0] = word;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_2ND;
    else        mode_q <= mash_mode_e'(order3);
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g < NSTAGE - 1) begin : g_mid
      mash_stage #(.W(ACC_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (adv),
        .addend   (link[g]),
        .sum_next (link[g+1]),
        .carry    (carry[g])
      );
    end else begin : g_last
      mash_stage #(.W(ACC_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (adv),
        .addend   (link[g]),
        .sum_next (tail_unused),
        .carry    (carry[g])
      );
    end
  end

  mash_combine #(.OUT_W(OUT_W)) u_comb (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .adv    (adv),
    .mode3  (order3),
    .c1     (carry[0]),
    .c2     (carry[1]),
    .c3     (carry[2]),
    .offset (offset)
  );
endmodule

// File: rtl/mash_sdm_chk.sv
module mash_sdm_chk #(
  parameter int FRAC_W = 18,
  parameter int OUT_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [FRAC_W-1:0]       frac_k,
  input logic                    order3,
  input logic                    step_en,
  input logic signed [OUT_W-1:0] offset
);
  // R3: second-order output set
  a_r3_range_2nd: assert property (@(posedge clk) disable iff (!rst_n)
    (!order3 && !$past(order3)) |-> (int'(offset) >= -1 && int'(offset) <= 2));

  // R4: third-order output set
  a_r4_range_3rd: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) >= -3 && int'(offset) <= 4));

  // R5: zero word forces integer operation
  a_r5_kzero: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_k == '0) |=> (offset == '0));

  // R6: no strobe, no movement
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && frac_k != '0 && $stable(order3)) |=> $stable(offset));

  // R7: an order change clears the output
  a_r7_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (order3 != $past(order3)) |=> (offset == '0));
endmodule

bind mash_sdm mash_sdm_chk #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .frac_k  (frac_k),
  .order3  (order3),
  .step_en (step_en),
  .offset  (offset)
);

// File: tb/test_mash_sdm.sv
`timescale 1ns/1ps
module test_mash_sdm;
  localparam int FRAC_W = 18;
  localparam int OUT_W  = 4;
  localparam int FULL   = 1 << (FRAC_W + 1);

  typedef struct packed {
    logic [17:0] k;
    logic        l;
    logic        m3;
    logic [1:0]  gap;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{k: 18'h00001, l: 1'b0, m3: 1'b0, gap: 2'd0, n: 16'd4096},
    '{k: 18'h20000, l: 1'b0, m3: 1'b1, gap: 2'd0, n: 16'd4096},
    '{k: 18'h3FFFF, l: 1'b1, m3: 1'b1, gap: 2'd1, n: 16'd2048},
    '{k: 18'h12345, l: 1'b1, m3: 1'b0, gap: 2'd2, n: 16'd2048},
    '{k: 18'h0ABCD, l: 1'b0, m3: 1'b1, gap: 2'd0, n: 16'd8192},
    '{k: 18'h00001, l: 1'b1, m3: 1'b1, gap: 2'd0, n: 16'd4096}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FRAC_W-1:0] frac_k = '0;
  logic lsb_en = 1'b0;
  logic order3 = 1'b0;
  logic step_en = 1'b0;
  logic signed [OUT_W-1:0] offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  int m_a1, m_a2, m_a3, m_c2p, m_c3p, m_c3pp;

  always #4 clk = ~clk;

  mash_sdm #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_mash_sdm (
    .clk(clk), .rst_n(rst_n), .frac_k(frac_k), .lsb_en(lsb_en),
    .order3(order3), .step_en(step_en), .offset(offset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2p = 0; m_c3p = 0; m_c3pp = 0;
  endfunction

  function automatic int model_step(input int x, input bit m3);
    int c1, c2, c3, y;
    m_a1 = m_a1 + x;    c1 = (m_a1 >= FULL) ? 1 : 0; m_a1 = m_a1 % FULL;
    m_a2 = m_a2 + m_a1; c2 = (m_a2 >= FULL) ? 1 : 0; m_a2 = m_a2 % FULL;
    m_a3 = m_a3 + m_a2; c3 = (m_a3 >= FULL) ? 1 : 0; m_a3 = m_a3 % FULL;
    y = c1 + c2 - m_c2p;
    if (m3) y = y + c3 - 2 * m_c3p + m_c3pp;
    m_c2p = c2; m_c3pp = m_c3p; m_c3p = c3;
    return y;
  endfunction

  // starts and ends at a negedge with step_en low
  task automatic do_reset(input logic [17:0] k, input logic l, input logic m3);
    frac_k = k; lsb_en = l; order3 = m3; step_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    model_clear();
  endtask

  // one strobe; returns the output seen after it
  task automatic strobe(output int val);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    val = int'(offset);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v, x;
    // R1: reset state
    do_reset(18'h00123, 1'b0, 1'b1);
    chk(offset == '0, "R1", int'(offset), 0);

    foreach (VEC[i]) begin
      int mism, lo, hi, hold_bad, sum, last;
      longint c1_tot;
      do_reset(VEC[i].k, VEC[i].l, VEC[i].m3);
      x = 2 * int'(VEC[i].k) + int'(VEC[i].l);
      mism = 0; hold_bad = 0; sum = 0; lo = 99; hi = -99; last = 0;
      for (int s = 0; s < int'(VEC[i].n); s++) begin
        int e;
        strobe(v);
        e = model_step(x, VEC[i].m3);
        if (v != e) begin
          if (mism == 0) chk(1'b0, "R2", v, e);
          mism++;
        end
        sum += v;
        if (v < lo) lo = v;
        if (v > hi) hi = v;
        last = v;
        for (int g = 0; g < int'(VEC[i].gap); g++) begin
          @(negedge clk);
          if (int'(offset) != last) hold_bad++;
        end
      end
      if (mism == 0) chk(1'b1, "R2", 0, 0);
      if (VEC[i].gap != 0) chk(hold_bad == 0, "R6", hold_bad, 0);
      if (VEC[i].m3) begin
        chk(lo >= -3 && hi <= 4, "R4 min", lo, -3);
        chk(lo >= -3 && hi <= 4, "R4 max", hi, 4);
      end else begin
        chk(lo >= -1 && hi <= 2, "R3 min", lo, -1);
        chk(lo >= -1 && hi <= 2, "R3 max", hi, 2);
      end
      c1_tot = (longint'(VEC[i].n) * longint'(x)) >>> (FRAC_W + 1);
      chk((longint'(sum) - c1_tot <= 3) && (c1_tot - longint'(sum) <= 3),
          "R8", sum, int'(c1_tot));
    end

    // R5: zero word, extra LSB set, third order
    begin
      int nz;
      do_reset(18'h00000, 1'b1, 1'b1);
      nz = 0;
      for (int s = 0; s < 20; s++) begin
        strobe(v);
        if (v != 0) nz++;
      end
      chk(nz == 0, "R5 zero output", nz, 0);
      // leave integer mode: sequence restarts from a clear state
      frac_k = 18'h2AAAA;
      model_clear();
      x = 2 * 18'h2AAAA + 1;
      nz = 0;
      for (int s = 0; s < 50; s++) begin
        int e;
        strobe(v);
        e = model_step(x, 1'b1);
        if (v != e) nz++;
      end
      chk(nz == 0, "R5 restart", nz, 0);
    end

    // R7: order change mid-stream, strobe held high through the change edge
    begin
      int nz, e;
      do_reset(18'h1F00F, 1'b0, 1'b1);
      x = 2 * 18'h1F00F;
      for (int s = 0; s < 37; s++) begin
        strobe(v);
        e = model_step(x, 1'b1);
      end
      order3 = 1'b0;
      strobe(v);
      chk(v == 0, "R7 clear", v, 0);
      model_clear();
      nz = 0;
      for (int s = 0; s < 64; s++) begin
        strobe(v);
        e = model_step(x, 1'b0);
        if (v != e) nz++;
      end
      chk(nz == 0, "R7 fresh sequence", nz, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule